// File: doc/BRIEF.md
# Dual-Bank Flash Busy Status Logic

This block belongs to a behavioural flash memory model whose array is split into two banks. It decides what a read returns while an embedded program or erase is running. It records which bank owns the running operation. It routes every read either to the array data or to a status word. A read aimed at the idle bank passes the array word through combinationally, so the other bank's operation adds no delay to it. A read aimed at the busy bank returns a status word that carries a data-polling bit and a toggle bit.

An active-low ready/busy output gives a hardware view of the same state. Only one embedded operation runs at a time. A start request that arrives while an operation is already running is refused and flagged. The command decoder issues single-cycle start pulses. Each pulse carries the target bank, the operation kind and bit 7 of the word being programmed. A timer issues a single-cycle done pulse when the operation ends.

The bank boundary is set by a parameter that picks the size of the small bank (bank 1) at the top of the address space. The four choices correspond to 1/64, 1/8, 1/4 or 1/2 of the array. For a 32-megabit part these are splits of 0.5/31.5, 4/28, 8/24 and 16/16 megabits.

Top module: `flash_dual_bank_status`

## Requirements
- R1: After reset, rdy is 1, start_err is 0 and rd_data equals arr_rdata for every address.
- R2: An address belongs to bank 1 when its top SPLIT_SHIFT bits are all ones, and to bank 0 otherwise. SPLIT_SHIFT is 6, 3, 2 or 1 for SPLIT_SEL 0, 1, 2 or 3. With the default SPLIT_SEL of 1 and a 21-bit address, bank 1 starts at 0x1C0000.
- R3: While an operation runs, a read whose address lies in the other bank returns arr_rdata in the same cycle.
- R4: While a program runs (op_erase = 0 at start), a read of the busy bank returns bit 7 equal to the complement of prog_d7 as captured at the start pulse.
- R5: While an erase runs (op_erase = 1 at start), a read of the busy bank returns bit 7 equal to 0.
- R6: In the status word, bit 6 is the toggle bit. It reads 0 on the first busy-bank read after a start and inverts after every cycle in which rd_en is 1 and the address hits the busy bank. Reads of the other bank leave it unchanged. Every status bit other than 7 and 6 is 0.
- R7: rdy goes to 0 in the cycle after an accepted start pulse. It stays 0 until the cycle after the done pulse, when it returns to 1.
- R8: Once an operation has completed, reads of the formerly busy bank return arr_rdata again.
- R9: A start pulse that arrives while an operation runs is ignored and leaves the running operation's bank, polling bit and toggle state unchanged. start_err is 1 for exactly the following cycle. A done pulse in the same cycle still ends the running operation.
- R10: A done pulse while no operation runs has no effect: rdy stays 1 and reads still return arr_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Single-cycle request to begin an embedded operation |
| op_bank | input | 1 | Target bank of the request (0 or 1) |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| op_done | input | 1 | Single-cycle completion pulse from the operation timer |
| rd_addr | input | ADDR_W | Word address of the current read |
| rd_en | input | 1 | Read strobe; each strobe to the busy bank advances the toggle bit |
| arr_rdata | input | DATA_W | Array word at rd_addr |
| rd_data | output | DATA_W | Word returned to the host |
| rdy | output | 1 | Ready/busy, 0 while an operation runs |
| start_err | output | 1 | One-cycle flag for a refused start request |

## Verification
The hardest situation to reach from the ports is a long run of interleaved reads to both banks while an operation is in flight. In that run the toggle bit must advance only on hits to the busy bank. A second hard case is a refused start that lands in the same cycle as the done pulse. Directed sequences place reads exactly on both sides of the bank boundary and collide a start with a done. A long pseudo-random phase then biases addresses toward the boundary and mixes starts, dones and strobes freely. A behavioural model compares every output on every cycle.

// File: rtl/flash_bs_pkg.sv
package flash_bs_pkg;

    // Status word bit positions decoded by the host polling routine
    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;

    // Number of top address bits that must be ones to select bank 1
    function automatic int split_shift(input int sel);
        case (sel)
            0:       return 6;
            1:       return 3;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    typedef struct packed {
        logic busy;   // an embedded operation is running
        logic bank;   // bank owning the running operation
        logic poll;   // value presented on the polling bit
        logic tog;    // current toggle bit
        logic err;    // refused start seen last cycle
    } trk_state_t;

endpackage

// File: rtl/flash_bank_map.sv
module flash_bank_map #(
    parameter int ADDR_W    = 21,
    parameter int SPLIT_SEL = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bank
);
    import flash_bs_pkg::*;

    localparam int SHIFT = split_shift(SPLIT_SEL);
    localparam logic [ADDR_W-1:0] BOUND =
        {{SHIFT{1'b1}}, {(ADDR_W-SHIFT){1'b0}}};

    always_comb begin
        bank = (addr >= BOUND);
    end
endmodule

// File: rtl/flash_op_track.sv
module flash_op_track (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic op_bank,
    input  logic op_erase,
    input  logic prog_d7,
    input  logic op_done,
    input  logic rd_en,
    input  logic rd_bank,
    output logic busy,
    output logic busy_bank,
    output logic poll,
    output logic tog,
    output logic err
);
    import flash_bs_pkg::*;

    trk_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        if (s_q.busy) begin
            if (op_start) begin
                s_d.err = 1'b1;
            end
            if (rd_en && (rd_bank == s_q.bank)) begin
                s_d.tog = ~s_q.tog;
            end
            if (op_done) begin
                s_d.busy = 1'b0;
            end
        end else if (op_start) begin
            s_d.busy = 1'b1;
            s_d.bank = op_bank;
            s_d.poll = op_erase ? 1'b0 : ~prog_d7;
            s_d.tog  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        busy      = s_q.busy;
        busy_bank = s_q.bank;
        poll      = s_q.poll;
        tog       = s_q.tog;
        err       = s_q.err;
    end
endmodule

// File: rtl/flash_rd_route.sv
module flash_rd_route #(
    parameter int DATA_W = 16
) (
    input  logic              busy,
    input  logic              busy_bank,
    input  logic              rd_bank,
    input  logic              poll,
    input  logic              tog,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);
    import flash_bs_pkg::*;

    logic [DATA_W-1:0] status_w;
    logic              hit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_stat
        if (i == POLL_BIT) begin : g_poll
            assign status_w[i] = poll;
        end else if (i == TOG_BIT) begin : g_tog
            assign status_w[i] = tog;
        end else begin : g_zero
            assign status_w[i] = 1'b0;
        end
    end

    always_comb begin
        hit     = busy && (rd_bank == busy_bank);
        rd_data = hit ? status_w : arr_rdata;
    end
endmodule

// File: rtl/flash_dual_bank_status.sv
module flash_dual_bank_status #(
    parameter int ADDR_W    = 21,
    parameter int DATA_W    = 16,
    parameter int SPLIT_SEL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_bank,
    input  logic              op_erase,
    input  logic              prog_d7,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              start_err
);
    logic rd_bank;
    logic busy, busy_bank, poll, tog;

    flash_bank_map #(
        .ADDR_W   (ADDR_W),
        .SPLIT_SEL(SPLIT_SEL)
    ) u_map (
        .addr(rd_addr),
        .bank(rd_bank)
    );

    flash_op_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_start (op_start),
        .op_bank  (op_bank),
        .op_erase (op_erase),
        .prog_d7  (prog_d7),
        .op_done  (op_done),
        .rd_en    (rd_en),
        .rd_bank  (rd_bank),
        .busy     (busy),
        .busy_bank(busy_bank),
        .poll     (poll),
        .tog      (tog),
        .err      (start_err)
    );

    flash_rd_route #(
        .DATA_W(DATA_W)
    ) u_route (
        .busy     (busy),
        .busy_bank(busy_bank),
        .rd_bank  (rd_bank),
        .poll     (poll),
        .tog      (tog),
        .arr_rdata(arr_rdata),
        .rd_data  (rd_data)
    );

    always_comb begin
        rdy = ~busy;
    end
endmodule

// File: rtl/flash_dual_bank_status_chk.sv
module flash_dual_bank_status_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic              op_done,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy,
    input logic              start_err
);
    // R7
    busy_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && rdy) |=> !rdy);

    // R7
    busy_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && op_done) |=> rdy);

    // R9
    refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_start && !rdy) |=> start_err);

    // R9
    no_spurious_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_start && !rdy) |=> !start_err);

    // R8
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> (rd_data == arr_rdata));

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !op_start) |=> rdy);
endmodule

bind flash_dual_bank_status flash_dual_bank_status_chk #(
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_start (op_start),
    .op_done  (op_done),
    .arr_rdata(arr_rdata),
    .rd_data  (rd_data),
    .rdy      (rdy),
    .start_err(start_err)
);

// File: tb/sim_flash_dual_bank_status.sv
`timescale 1ns/100ps
module sim_flash_dual_bank_status;
    localparam int AW = 21;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0, op_bank = 1'b0, op_erase = 1'b0;
    logic          prog_d7 = 1'b0, op_done = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] rd_data;
    logic          rdy, start_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // behavioural reference state
    bit m_busy = 0, m_bank = 0, m_poll = 0, m_tog = 0, m_err = 0;

    always #2.5 clk = ~clk;

    // array stand-in: word derived from the address
    assign arr_rdata = rd_addr[15:0] ^ {rd_addr[20:16], 11'h5A3};

    flash_dual_bank_status u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_bank(op_bank),
        .op_erase(op_erase), .prog_d7(prog_d7), .op_done(op_done),
        .rd_addr(rd_addr), .rd_en(rd_en), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .rdy(rdy), .start_err(start_err)
    );

    // R2: bank 1 is the top eighth of the space for the default split
    function automatic bit bank_of(input logic [AW-1:0] a);
        return a >= 21'h1C0000;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic step(input bit st, input bit bk, input bit er,
                        input bit d7, input bit dn,
                        input logic [AW-1:0] a, input bit rd,
                        input string tag);
        bit hit;
        logic [DW-1:0] exp_d;
        string t;
        @(negedge clk);
        op_start = st; op_bank = bk; op_erase = er; prog_d7 = d7;
        op_done = dn; rd_addr = a; rd_en = rd;
        #1;
        hit = m_busy && (bank_of(a) == m_bank);
        exp_d = arr_rdata;
        if (hit) begin
            exp_d = '0;
            exp_d[7] = m_poll;
            exp_d[6] = m_tog;
        end
        if (tag != "") t = tag;
        else if (hit) t = "R4 R5 R6";
        else if (m_busy) t = "R3";
        else t = "R8";
        check(t, rd_data, exp_d);
        check((tag != "") ? tag : "R7", {15'd0, rdy}, {15'd0, !m_busy});
        check((tag != "") ? tag : "R9", {15'd0, start_err}, {15'd0, m_err});
        @(posedge clk);
        m_err = st && m_busy;
        if (m_busy) begin
            if (rd && hit) m_tog = !m_tog;
            if (dn) m_busy = 0;
        end else if (st) begin
            m_busy = 1; m_bank = bk; m_poll = er ? 1'b0 : !d7; m_tog = 0;
        end
    endtask

    task automatic idle_rd(input logic [AW-1:0] a, input string tag);
        step(0, 0, 0, 0, 0, a, 1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state across both banks
        idle_rd(21'h000010, "R1");
        idle_rd(21'h1FFFF0, "R1");

        // program bank 0 with d7=1 -> polling bit 0 (R4)
        step(1, 0, 0, 1, 0, 21'h000100, 0, "");
        idle_rd(21'h000100, "R4 R6");   // DQ6 = 0
        idle_rd(21'h000200, "R4 R6");   // DQ6 = 1
        idle_rd(21'h1C0004, "R3");      // other bank, array data
        idle_rd(21'h000300, "R6");      // toggle not moved by R3 read
        step(0, 0, 0, 0, 1, 21'h000300, 1, "R6");
        idle_rd(21'h000300, "R8");
        idle_rd(21'h000400, "R7");

        // erase bank 1, boundary reads (R2, R5)
        step(1, 1, 1, 1, 0, 21'h0, 0, "");
        idle_rd(21'h1C0000, "R2 R5");
        idle_rd(21'h1BFFFF, "R2");
        idle_rd(21'h1FFFFF, "R2 R6");
        // refused start to bank 0 (R9), then status unchanged
        step(1, 0, 0, 0, 0, 21'h1C0010, 0, "R9");
        idle_rd(21'h1C0010, "R9");
        idle_rd(21'h000020, "R9");
        // refused start colliding with done (R9)
        step(1, 0, 0, 0, 1, 21'h000020, 0, "R9");
        idle_rd(21'h1C0010, "R9");
        idle_rd(21'h1C0010, "R8");

        // done while idle (R10)
        step(0, 0, 0, 0, 1, 21'h1C0020, 1, "R10");
        idle_rd(21'h1C0020, "R10");

        // program bank 1 with d7=0 -> polling bit 1 (R4)
        step(1, 1, 0, 0, 0, 21'h0, 0, "");
        idle_rd(21'h1E0000, "R4");
        step(0, 0, 0, 0, 1, 21'h1E0000, 0, "R7");
        idle_rd(21'h1E0000, "R8");

        // mixed pseudo-random phase
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            a = $urandom_range(0, 3) == 0 ?
                21'h1C0000 + AW'($urandom_range(0, 7)) - 21'd4 :
                AW'($urandom());
            step($urandom_range(0, 19) == 0, 1'($urandom()), 1'($urandom()),
                 1'($urandom()), $urandom_range(0, 14) == 0, a,
                 1'($urandom()), "");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule